// File: doc/BRIEF.md
# Split-Mode Up-Counting Timer

This block is a register-mapped timer built from one double-width up-counter that software can use either whole or as two independent single-width halves, named low and high. In split use every half owns a count register, a period register, a two-bit run-mode field and its own interrupt line. When a running half reaches its period, it returns to zero and pulses its interrupt. In periodic mode it keeps going. In one-shot mode it disables itself.

A global control register chooses between the whole-counter and split arrangements and carries one release bit per half. A half whose release bit is low is held at zero. Software reaches all registers through a simple write-strobe bus with a combinational read port. It may load any count directly, which is how it clears or presets a counter. A period of all ones turns a half into a free-running counter that raises its interrupt at every wrap.

Top module: `split_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Registers sit at these byte offsets: low count 0x10, high count 0x14, low period 0x18, high period 0x1C, run control 0x20, global control 0x24. Run control returns only its two fields, and global control returns only bits 3:0. Any other offset reads zero.
- R3: In split arrangement, a released half whose run-mode field is nonzero and whose count differs from its period adds one to its count on each clock. Run-mode codes are 0 stopped, 1 one-shot, 2 periodic. The low field is run-control bits 7:6 and the high field is bits 23:22.
- R4: When a running half's count equals its period, the count becomes zero on that clock and the half's interrupt is high for exactly the following cycle. In periodic mode counting then resumes.
- R5: A match in one-shot mode also writes that half's run-mode field to 0. A bus write to run control in the same cycle takes precedence.
- R6: With its run-mode field at 0, a released half keeps its count unchanged.
- R7: Global control bit 0 releases the low half and bit 1 releases the high half. While a bit is 0, that half's count is forced to zero and bus loads are ignored. In the whole-counter arrangement both halves are held unless both bits are 1.
- R8: A bus write to a count register loads that value on the same clock edge, overriding counting and match clearing.
- R9: With the period at all ones, the count wraps from all ones to zero and the interrupt fires at each wrap.
- R10: Global control bits 3:2 select the arrangement: code 0 is the whole counter and every other code gives split halves. In the whole counter the two counts and the two periods form the low and high words of one value. The low run-mode field governs that value. Carries pass from low to high. A match pulses only the low interrupt, and the high interrupt stays low.
- R11: In split arrangement the high half runs and interrupts independently of the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| irq_lo | output | 1 | Low half (or whole counter) match pulse |
| irq_hi | output | 1 | High half match pulse |

## Verification
The low half runs periodic with a small period, which separates the count-then-clear sequence from a plain wrap and confirms the pulse recurs. A one-shot run with a different period shows the field clearing itself and the count staying at zero afterwards. A high-half run with the high half held, then released and preloaded just below its period, separates hold behaviour from load priority. The all-ones period and the whole-counter carry across the word boundary each exercise the widest compare, and the whole-counter match confirms only the low line pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned OFS_CNT_LO = 32'h10;
   localparam int unsigned OFS_CNT_HI = 32'h14;
   localparam int unsigned OFS_PRD_LO = 32'h18;
   localparam int unsigned OFS_PRD_HI = 32'h1C;
   localparam int unsigned OFS_RUNCTL = 32'h20;
   localparam int unsigned OFS_GLBCTL = 32'h24;

   localparam int RUN_LO_POS = 6;
   localparam int RUN_HI_POS = 22;
   localparam int ARR_POS    = 2;

   typedef enum logic [1:0] {
      RUN_STOP     = 2'd0,
      RUN_ONCE     = 2'd1,
      RUN_CYCLIC   = 2'd2
   } run_mode_e;

   localparam logic [1:0] ARR_WHOLE = 2'd0;
endpackage

// File: rtl/tmr_half.sv
module tmr_half #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          clear,
   input  logic          step,
   output logic [DW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (hold)   cnt <= '0;
      else if (load)   cnt <= load_val;
      else if (clear)  cnt <= '0;
      else if (step)   cnt <= cnt + DW'(1);
   end
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
   import tmr_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] cnt_lo,
   input  logic [DW-1:0] cnt_hi,
   input  logic          os_clr_lo,
   input  logic          os_clr_hi,
   output logic [DW-1:0] prd_lo,
   output logic [DW-1:0] prd_hi,
   output logic [1:0]    run_lo,
   output logic [1:0]    run_hi,
   output logic [1:0]    arr,
   output logic [1:0]    rel,
   output logic          wr_cnt_lo,
   output logic          wr_cnt_hi,
   output logic          wr_runctl,
   output logic [DW-1:0] rdata
);
   logic sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi, sel_run, sel_glb;

   assign sel_cnt_lo = (addr == AW'(OFS_CNT_LO));
   assign sel_cnt_hi = (addr == AW'(OFS_CNT_HI));
   assign sel_prd_lo = (addr == AW'(OFS_PRD_LO));
   assign sel_prd_hi = (addr == AW'(OFS_PRD_HI));
   assign sel_run    = (addr == AW'(OFS_RUNCTL));
   assign sel_glb    = (addr == AW'(OFS_GLBCTL));

   assign wr_cnt_lo = we && sel_cnt_lo;
   assign wr_cnt_hi = we && sel_cnt_hi;
   assign wr_runctl = we && sel_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prd_lo <= '0;
         prd_hi <= '0;
      end else if (we) begin
         if (sel_prd_lo) prd_lo <= wdata;
         if (sel_prd_hi) prd_hi <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_lo <= RUN_STOP;
         run_hi <= RUN_STOP;
      end else if (wr_runctl) begin
         run_lo <= wdata[RUN_LO_POS +: 2];
         run_hi <= wdata[RUN_HI_POS +: 2];
      end else begin
         if (os_clr_lo) run_lo <= RUN_STOP;
         if (os_clr_hi) run_hi <= RUN_STOP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr <= ARR_WHOLE;
         rel <= '0;
      end else if (we && sel_glb) begin
         arr <= wdata[ARR_POS +: 2];
         rel <= wdata[1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_cnt_lo)      rdata = cnt_lo;
      else if (sel_cnt_hi) rdata = cnt_hi;
      else if (sel_prd_lo) rdata = prd_lo;
      else if (sel_prd_hi) rdata = prd_hi;
      else if (sel_run) begin
         rdata[RUN_LO_POS +: 2] = run_lo;
         rdata[RUN_HI_POS +: 2] = run_hi;
      end else if (sel_glb) begin
         rdata[ARR_POS +: 2] = arr;
         rdata[1:0]          = rel;
      end
   end
endmodule

// File: rtl/split_timer.sv
module split_timer
   import tmr_pkg::*;
#(
   parameter int DW      = 32,
   parameter int AW      = 8,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq_lo,
   output logic          irq_hi
);
   localparam int NH = 2;

   if (DW < 24) begin : g_bad_dw
      $error("split_timer: DW must be at least 24 to hold the run-control fields");
   end
   if (AW < 6) begin : g_bad_aw
      $error("split_timer: AW must be at least 6 to reach offset 0x24");
   end

   logic [DW-1:0] cnt_lo, cnt_hi, prd_lo, prd_hi;
   logic [1:0]    run_lo, run_hi, arr, rel;
   logic          rel_lo, rel_hi;
   logic          wr_cnt_lo, wr_cnt_hi, wr_runctl;
   logic          os_clr_lo, os_clr_hi;
   logic          split;
   logic          wide_run, wide_match;

   logic [DW-1:0] cnt_q   [NH];
   logic [DW-1:0] prd_v   [NH];
   logic [1:0]    run_v   [NH];
   logic [NH-1:0] rel_v, load_v, hold_v, clear_v, step_v, run_s, match_s;

   tmr_regfile #(.DW(DW), .AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .cnt_lo    (cnt_lo),
      .cnt_hi    (cnt_hi),
      .os_clr_lo (os_clr_lo),
      .os_clr_hi (os_clr_hi),
      .prd_lo    (prd_lo),
      .prd_hi    (prd_hi),
      .run_lo    (run_lo),
      .run_hi    (run_hi),
      .arr       (arr),
      .rel       (rel),
      .wr_cnt_lo (wr_cnt_lo),
      .wr_cnt_hi (wr_cnt_hi),
      .wr_runctl (wr_runctl),
      .rdata     (bus_rdata)
   );

   assign rel_lo = rel[0];
   assign rel_hi = rel[1];

   assign prd_v[0] = prd_lo;
   assign prd_v[1] = prd_hi;
   assign run_v[0] = run_lo;
   assign run_v[1] = run_hi;
   assign rel_v    = rel;
   assign load_v   = {wr_cnt_hi, wr_cnt_lo};

   // Whole-counter variant: present only when the parameter asks for it.
   if (WIDE_EN) begin : g_wide
      assign split      = (arr != ARR_WHOLE);
      assign wide_run   = rel_lo && rel_hi && (run_lo != RUN_STOP);
      assign wide_match = wide_run && ({cnt_hi, cnt_lo} == {prd_hi, prd_lo});
   end else begin : g_narrow
      assign split      = 1'b1;
      assign wide_run   = 1'b0;
      assign wide_match = 1'b0;
   end

   for (genvar h = 0; h < NH; h++) begin : g_half
      assign run_s[h]   = rel_v[h] && (run_v[h] != RUN_STOP);
      assign match_s[h] = run_s[h] && (cnt_q[h] == prd_v[h]);

      assign hold_v[h]  = split ? !rel_v[h] : !(rel_lo && rel_hi);
      assign clear_v[h] = split ? match_s[h] : wide_match;

      if (h == 0) begin : g_step_lo
         assign step_v[h] = split ? (run_s[h] && !match_s[h])
                                  : (wide_run && !wide_match);
      end else begin : g_step_hi
         assign step_v[h] = split ? (run_s[h] && !match_s[h])
                                  : (wide_run && !wide_match && (&cnt_lo));
      end

      tmr_half #(.DW(DW)) u_half (
         .clk      (clk),
         .rst_n    (rst_n),
         .hold     (hold_v[h]),
         .load     (load_v[h]),
         .load_val (bus_wdata),
         .clear    (clear_v[h]),
         .step     (step_v[h]),
         .cnt      (cnt_q[h])
      );
   end

   assign cnt_lo = cnt_q[0];
   assign cnt_hi = cnt_q[1];

   assign os_clr_lo = (split ? match_s[0] : wide_match) && (run_lo == RUN_ONCE);
   assign os_clr_hi = split && match_s[1] && (run_hi == RUN_ONCE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_lo <= 1'b0;
         irq_hi <= 1'b0;
      end else begin
         irq_lo <= split ? match_s[0] : wide_match;
         irq_hi <= split && match_s[1];
      end
   end
endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk #(
   parameter int DW      = 32,
   parameter bit WIDE_EN = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] cnt_lo,
   input logic [DW-1:0] prd_lo,
   input logic [1:0]    run_lo,
   input logic [1:0]    arr,
   input logic          rel_lo,
   input logic          rel_hi,
   input logic          wr_cnt_lo,
   input logic          wr_runctl,
   input logic          irq_lo,
   input logic          irq_hi
);
   logic chk_split;
   assign chk_split = !WIDE_EN || (arr != 2'd0);

   // R3: released, running, unmatched, not loaded -> count advances by one
   a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_split && rel_lo && run_lo != 2'd0 && cnt_lo != prd_lo && !wr_cnt_lo)
      |=> (cnt_lo == $past(cnt_lo) + DW'(1)));

   // R4: an interrupt pulse coincides with a count of zero
   a_r4_irq_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lo && !$past(wr_cnt_lo)) |-> (cnt_lo == '0));

   // R5: a one-shot match stops the half
   a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_split && rel_lo && run_lo == 2'd1 && cnt_lo == prd_lo && !wr_runctl)
      |=> (run_lo == 2'd0));

   // R6: stopped and released -> count frozen
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_lo && rel_hi && run_lo == 2'd0 && !wr_cnt_lo)
      |=> $stable(cnt_lo));

   // R7: a held half reads zero on the next cycle
   a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_lo |=> (cnt_lo == '0));

   // R10: whole-counter arrangement never pulses the high line
   a_r10_no_hi_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDE_EN && arr == 2'd0 && $past(arr) == 2'd0) |-> !irq_hi);
endmodule

bind split_timer split_timer_chk #(.DW(DW), .WIDE_EN(WIDE_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_lo    (cnt_lo),
   .prd_lo    (prd_lo),
   .run_lo    (run_lo),
   .arr       (arr),
   .rel_lo    (rel_lo),
   .rel_hi    (rel_hi),
   .wr_cnt_lo (wr_cnt_lo),
   .wr_runctl (wr_runctl),
   .irq_lo    (irq_lo),
   .irq_hi    (irq_hi)
);

// File: tb/tb_split_timer.sv
module tb_split_timer;
   localparam int CLK_PERIOD = 10;
   localparam int K_REG = 0, K_IRQL = 1, K_IRQH = 2;
   localparam logic [7:0] A_CL = 8'h10, A_CH = 8'h14, A_PL = 8'h18, A_PH = 8'h1C,
                          A_RC = 8'h20, A_GC = 8'h24;

   typedef struct {
      int          due;
      int          kind;
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  wr_addr = '0, view_addr = '0, bus_addr;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq_lo, irq_hi;
   int          cyc = 0, n_chk = 0, n_fail = 0;
   bit          done = 1'b0;
   item_t       q[$];
   item_t       mon_it;
   logic [31:0] act;

   assign bus_addr = bus_we ? wr_addr : view_addr;

   split_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // driver side: queue an expectation n clock edges after the current state
   task automatic expect_at(input int n, input int kind, input logic [7:0] a,
                            input logic [31:0] e, input string tag);
      item_t it;
      it.due = cyc + n; it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wait (q.size() == 0);
      @(posedge clk); #1;
      bus_we = 1'b1; wr_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   // monitor side: pop and compare as results appear
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         mon_it = q.pop_front();
         if (mon_it.kind == K_REG) begin
            view_addr = mon_it.addr;
            #1;
            act = bus_rdata;
         end else if (mon_it.kind == K_IRQL) act = {31'b0, irq_lo};
         else act = {31'b0, irq_hi};
         n_chk++;
         if (mon_it.due != cyc || act !== mon_it.exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", mon_it.tag, act, mon_it.exp);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      // R1 reset state, R2 unmapped read
      expect_at(0, K_REG, A_CL, 32'h0, "R1 low count");
      expect_at(0, K_REG, A_PH, 32'h0, "R1 high period");
      expect_at(0, K_REG, A_GC, 32'h0, "R1 global control");
      expect_at(0, K_IRQL, 8'h0, 32'h0, "R1 irq_lo");
      expect_at(0, K_IRQH, 8'h0, 32'h0, "R1 irq_hi");
      expect_at(0, K_REG, 8'h30, 32'h0, "R2 unmapped offset");

      // R3/R4 periodic low half, period 3
      wr(A_GC, 32'h7);
      wr(A_PL, 32'd3);
      wr(A_CL, 32'd0);
      wr(A_RC, 32'h80);
      expect_at(0, K_REG, A_CL, 32'd0, "R3 start");
      expect_at(1, K_REG, A_CL, 32'd1, "R3 step 1");
      expect_at(3, K_REG, A_CL, 32'd3, "R3 step 3");
      expect_at(4, K_IRQL, 8'h0, 32'd1, "R4 match pulse");
      expect_at(4, K_REG, A_CL, 32'd0, "R4 clear on match");
      expect_at(5, K_IRQL, 8'h0, 32'd0, "R4 single cycle");
      expect_at(5, K_REG, A_CL, 32'd1, "R4 resumes");
      expect_at(8, K_IRQL, 8'h0, 32'd1, "R4 periodic repeat");

      // R6 freeze, R8 load
      wr(A_RC, 32'h0);
      wr(A_CL, 32'd5);
      expect_at(0, K_REG, A_CL, 32'd5, "R8 load");
      expect_at(3, K_REG, A_CL, 32'd5, "R6 frozen");
      expect_at(3, K_IRQL, 8'h0, 32'd0, "R6 no irq");

      // R5 one-shot, period 2
      wr(A_PL, 32'd2);
      wr(A_CL, 32'd0);
      wr(A_RC, 32'h40);
      expect_at(2, K_REG, A_CL, 32'd2, "R5 count");
      expect_at(3, K_IRQL, 8'h0, 32'd1, "R5 pulse");
      expect_at(3, K_REG, A_RC, 32'h0, "R5 field cleared");
      expect_at(5, K_REG, A_CL, 32'd0, "R5 stopped");
      expect_at(5, K_IRQL, 8'h0, 32'd0, "R5 no repeat");

      // R7 hold of the high half, R11 independent high interrupt
      wr(A_GC, 32'h5);
      wr(A_RC, 32'h0080_0000);
      wr(A_PH, 32'd10);
      wr(A_CH, 32'd7);
      expect_at(0, K_REG, A_CH, 32'd0, "R7 load ignored in hold");
      expect_at(3, K_REG, A_CH, 32'd0, "R7 held");
      wr(A_GC, 32'h7);
      expect_at(0, K_REG, A_CH, 32'd0, "R7 release edge");
      expect_at(2, K_REG, A_CH, 32'd2, "R7 counts after release");
      wr(A_CH, 32'd9);
      expect_at(0, K_REG, A_CH, 32'd9, "R8 load over counting");
      expect_at(1, K_REG, A_CH, 32'd10, "R11 reaches period");
      expect_at(2, K_IRQH, 8'h0, 32'd1, "R11 irq_hi");
      expect_at(2, K_IRQL, 8'h0, 32'd0, "R11 irq_lo quiet");
      expect_at(2, K_REG, A_CH, 32'd0, "R11 clear");
      expect_at(3, K_IRQH, 8'h0, 32'd0, "R11 single cycle");

      // R9 free-running wrap
      wr(A_PL, 32'hFFFF_FFFF);
      wr(A_CL, 32'hFFFF_FFFE);
      wr(A_RC, 32'h0080_0080);
      expect_at(1, K_REG, A_CL, 32'hFFFF_FFFF, "R9 top");
      expect_at(2, K_IRQL, 8'h0, 32'd1, "R9 wrap irq");
      expect_at(2, K_REG, A_CL, 32'd0, "R9 wrap");
      expect_at(3, K_REG, A_CL, 32'd1, "R9 continues");

      // R10 whole counter, period 0x1_0000_0000
      wr(A_RC, 32'h0);
      wr(A_GC, 32'h3);
      wr(A_PL, 32'd0);
      wr(A_PH, 32'd1);
      wr(A_CL, 32'hFFFF_FFFE);
      wr(A_CH, 32'd0);
      wr(A_RC, 32'h80);
      expect_at(1, K_REG, A_CL, 32'hFFFF_FFFF, "R10 low top");
      expect_at(1, K_REG, A_CH, 32'd0, "R10 high before carry");
      expect_at(2, K_REG, A_CL, 32'd0, "R10 low wrap");
      expect_at(2, K_REG, A_CH, 32'd1, "R10 carry");
      expect_at(3, K_IRQL, 8'h0, 32'd1, "R10 irq_lo on match");
      expect_at(3, K_IRQH, 8'h0, 32'd0, "R10 irq_hi quiet");
      expect_at(3, K_REG, A_CH, 32'd0, "R10 high clear");
      expect_at(4, K_REG, A_CL, 32'd1, "R10 resumes");
      expect_at(4, K_REG, A_GC, 32'h3, "R2 global readback");
      expect_at(4, K_REG, A_RC, 32'h80, "R2 run control readback");

      wait (q.size() == 0);
      @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule